// File: doc/BRIEF.md
# Floppy Stepper Phase Sequencer

This block sits between a floppy-drive step/direction interface and a two-phase stepper motor driver. It takes an active-low step strobe and an active-low direction level, both asynchronous to the system clock. Each step is qualified by its width, the drive select, the absence of a write and the track limits. An accepted step moves a two-bit Gray-coded phase state one position forward or backward. The phase change happens on the rising (trailing) edge of the strobe.

A track counter follows the head position. The block drives an active-low track-zero indicator and a one-clock pulse for every carriage move. It also watches the direction line around each step and flags a timing violation when direction was not held steady long enough before or after the strobe's trailing edge. The motor drivers and the mechanics lie outside the block.

Top module: `floppy_stepper`

## Requirements
- R1: After reset the phase output is 00, the track is 0, the track-zero indicator is low, and the step pulse and violation outputs are low.
- R2: A low strobe lasting STEP_MIN_NS or less (10 clocks or fewer at 20 ns) is ignored. A low strobe lasting longer (11 clocks or more) is a step request.
- R3: Position and phase do not change while the strobe is held low. They change only after the strobe returns high.
- R4: With direction low, an accepted step increments the track by one. The phase then equals the Gray code of track mod 4, with phase[1] = track[1] and phase[0] = track[1] XOR track[0], giving the order 00, 01, 11, 10.
- R5: With direction high, an accepted step decrements the track by one and walks the same Gray order backwards.
- R6: A step request is ignored while the drive is not selected (select low) or while a write is in progress (write high).
- R7: An outward step (direction high) at track 0 is ignored. An inward step at track TRACK_MAX (39) is ignored.
- R8: The track-zero indicator is low exactly when the track is 0 and the phase is 00, and is high otherwise.
- R9: Each accepted step produces exactly one step pulse, one clock wide. Rejected requests produce none.
- R10: A violation pulse is raised when direction changed less than DIR_SETUP_NS before a step's trailing edge.
- R11: A violation pulse is raised when direction changes less than DIR_HOLD_NS after a step's trailing edge.
- R12: No violation pulse is raised when direction is held steady over both windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| step_n | input | 1 | Active-low step strobe, asynchronous |
| dir_n | input | 1 | Direction level, low = inward (higher tracks), asynchronous |
| sel | input | 1 | Drive selected, active high |
| wr_busy | input | 1 | Write in progress, active high |
| phase | output | 2 | Stepper phase state, Gray coded |
| track | output | TRK_W (6) | Current track number |
| trk0_n | output | 1 | Active-low track-zero indicator |
| step_pulse | output | 1 | One-clock pulse per accepted step |
| dir_viol | output | 1 | One-clock pulse on a direction timing violation |

## Verification
The bench sends strobes just below and just above the minimum width. A design that counted one clock too few would accept the 10-clock pulse, and one that counted too many would reject the 11-clock pulse. It also holds a strobe low for a long time. A design that moved on the leading edge would show a new track while the strobe is still low. It walks the head to both track ends and then pushes past them. A design that did not check the limits would wrap the counter or leave a phase state that no longer matches the track. The direction line is toggled just before and just after a step to show that each window raises its own flag, and is kept steady elsewhere to show that no flag is raised then.

// File: rtl/stp_pkg.sv
package stp_pkg;

    typedef logic [1:0] phase_t;

    // Reversible Gray sequencer: low bit flips when (p1 ^ p0 ^ inward) is set,
    // otherwise the high bit flips.
    function automatic phase_t phase_step(input phase_t p, input logic inward);
        phase_t r;
        logic   flip_lo;
        flip_lo = p[1] ^ p[0] ^ inward;
        r       = p;
        if (flip_lo) r[0] = ~p[0];
        else         r[1] = ~p[1];
        return r;
    endfunction

endpackage

// File: rtl/stp_sync.sv
module stp_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;
endmodule

// File: rtl/stp_step_filter.sv
module stp_step_filter #(
    parameter int MIN_CYC = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_s,
    output logic trail
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_CYC);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d.prev = step_s;
        if (!step_s) begin
            st_d.cnt = (st_q.cnt == CMAX) ? st_q.cnt : st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trail = step_s & ~st_q.prev & (st_q.cnt == CMAX);

    // R3: an event marks a rising edge of the synchronized strobe
    a_r3_trailing_edge: assert property (@(posedge clk) disable iff (!rst_n)
        trail |-> (step_s && !$past(step_s)));

    // R2: the strobe was low for at least the two cycles before the event
    a_r2_low_before: assert property (@(posedge clk) disable iff (!rst_n)
        trail |-> ($past(step_s, 1) == 1'b0 && $past(step_s, 2) == 1'b0));
endmodule

// File: rtl/stp_dir_guard.sv
module stp_dir_guard #(
    parameter int SETUP_CYC = 5000,
    parameter int HOLD_CYC  = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_s,
    input  logic trail,
    output logic viol
);
    localparam int SW = $clog2(SETUP_CYC + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [SW-1:0] SMAX = SW'(SETUP_CYC);
    localparam logic [HW-1:0] HMAX = HW'(HOLD_CYC);

    typedef struct packed {
        logic          dir_prev;
        logic [SW-1:0] since;
        logic [HW-1:0] hold;
        logic          viol;
    } guard_t;

    guard_t st_d, st_q;
    logic   chg;

    always_comb begin
        chg = dir_s ^ st_q.dir_prev;
        st_d.dir_prev = dir_s;

        if (chg)                st_d.since = '0;
        else if (st_q.since == SMAX) st_d.since = st_q.since;
        else                    st_d.since = st_q.since + 1'b1;

        if (trail)              st_d.hold = HMAX;
        else if (st_q.hold != '0) st_d.hold = st_q.hold - 1'b1;
        else                    st_d.hold = '0;

        st_d.viol = (trail && (chg || (st_q.since < SMAX)))
                  || (chg && (st_q.hold != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir_prev <= 1'b1;
            st_q.since    <= '0;
            st_q.hold     <= '0;
            st_q.viol     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign viol = st_q.viol;

    // R11: the hold window counts down one per clock between steps
    a_r11_hold_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold != '0 && !trail) |=> (st_q.hold == $past(st_q.hold) - 1'b1));

    // R12: with no event and no open window, direction moves raise nothing
    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!trail && st_q.hold == '0) |=> !viol);
endmodule

// File: rtl/stp_position.sv
module stp_position
    import stp_pkg::*;
#(
    parameter int TRACK_MAX = 39,
    parameter int TRK_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trail,
    input  logic             dir_s,
    input  logic             sel,
    input  logic             wr_busy,
    output phase_t           phase,
    output logic [TRK_W-1:0] track,
    output logic             trk0_n,
    output logic             pulse
);
    localparam logic [TRK_W-1:0] TOP = TRK_W'(TRACK_MAX);

    typedef struct packed {
        phase_t           phase;
        logic [TRK_W-1:0] track;
        logic             trk0_n;
        logic             pulse;
    } pos_t;

    pos_t st_d, st_q;
    logic inward, blocked, accept;

    always_comb begin
        inward  = ~dir_s;
        blocked = inward ? (st_q.track == TOP) : (st_q.track == '0);
        accept  = trail & sel & ~wr_busy & ~blocked;

        st_d = st_q;
        st_d.pulse = accept;
        if (accept) begin
            st_d.phase = phase_step(st_q.phase, inward);
            st_d.track = inward ? st_q.track + 1'b1 : st_q.track - 1'b1;
        end
        st_d.trk0_n = ~((st_d.track == '0) && (st_d.phase == 2'b00));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= 2'b00;
            st_q.track  <= '0;
            st_q.trk0_n <= 1'b0;
            st_q.pulse  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase  = st_q.phase;
    assign track  = st_q.track;
    assign trk0_n = st_q.trk0_n;
    assign pulse  = st_q.pulse;

    // R4 / R5: each move flips exactly one phase bit
    a_r4_one_bit_flip: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> ($countones(phase ^ $past(phase)) == 1));

    // R7: track stays inside its range
    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        track <= TOP);

    // R9: a pulse always comes with a track move
    a_r9_pulse_moves: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (track != $past(track)));

    // R9: without a pulse the position holds
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |-> ($stable(track) && $stable(phase)));

    // R8: the indicator never shows zero away from track 0
    a_r8_zero_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (track != '0) |-> trk0_n);
endmodule

// File: rtl/floppy_stepper.sv
module floppy_stepper
    import stp_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int STEP_MIN_NS   = 200,
    parameter int DIR_SETUP_NS  = 100000,
    parameter int DIR_HOLD_NS   = 100000,
    parameter int TRACK_MAX     = 39,
    localparam int TRK_W        = $clog2(TRACK_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_n,
    input  logic             dir_n,
    input  logic             sel,
    input  logic             wr_busy,
    output logic [1:0]       phase,
    output logic [TRK_W-1:0] track,
    output logic             trk0_n,
    output logic             step_pulse,
    output logic             dir_viol
);
    localparam int MIN_CYC   = STEP_MIN_NS / CLK_PERIOD_NS + 1;
    localparam int SETUP_CYC = DIR_SETUP_NS / CLK_PERIOD_NS;
    localparam int HOLD_CYC  = DIR_HOLD_NS / CLK_PERIOD_NS;

    logic [1:0] sync_q;
    logic       step_s, dir_s, trail;
    phase_t     phase_w;

    stp_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({step_n, dir_n}),
        .q     (sync_q)
    );

    assign step_s = sync_q[1];
    assign dir_s  = sync_q[0];

    stp_step_filter #(.MIN_CYC(MIN_CYC)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_s (step_s),
        .trail  (trail)
    );

    stp_dir_guard #(.SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .dir_s (dir_s),
        .trail (trail),
        .viol  (dir_viol)
    );

    stp_position #(.TRACK_MAX(TRACK_MAX), .TRK_W(TRK_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .trail   (trail),
        .dir_s   (dir_s),
        .sel     (sel),
        .wr_busy (wr_busy),
        .phase   (phase_w),
        .track   (track),
        .trk0_n  (trk0_n),
        .pulse   (step_pulse)
    );

    assign phase = phase_w;
endmodule

// File: tb/test_floppy_stepper.sv
module test_floppy_stepper;
    localparam int TMAX = 39;
    localparam int WIN  = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_n = 1'b1, dir_n = 1'b1, sel = 1'b1, wr_busy = 1'b0;
    logic [1:0] phase;
    logic [5:0] track;
    logic trk0_n, step_pulse, dir_viol;

    int n_run = 0, n_fail = 0, m_track = 0, viol_cnt = 0, pulse_cnt = 0;
    int exp_q[$];
    bit pulse_prev = 1'b0, done = 1'b0;

    floppy_stepper #(.DIR_SETUP_NS(2000), .DIR_HOLD_NS(2000)) i_floppy_stepper (
        .clk(clk), .rst_n(rst_n), .step_n(step_n), .dir_n(dir_n), .sel(sel),
        .wr_busy(wr_busy), .phase(phase), .track(track), .trk0_n(trk0_n),
        .step_pulse(step_pulse), .dir_viol(dir_viol)
    );

    always #10 clk = ~clk;

    function automatic logic [1:0] gray_of(input int t);
        logic [1:0] b;
        b = 2'(t % 4);
        return {b[1], b[1] ^ b[0]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop on each pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (dir_viol) viol_cnt++;
            if (step_pulse) begin
                int e;
                pulse_cnt++;
                if (pulse_prev) chk("R9 pulse width", 2, 1);
                if (exp_q.size() == 0) chk("R9 unexpected pulse", 1, 0);
                else begin
                    e = exp_q.pop_front();
                    chk("R4/R5 track", int'(track), e);
                    chk("R4/R5 phase", int'(phase), int'(gray_of(e)));
                end
            end
            pulse_prev = step_pulse;
        end
    end

    // driver: one strobe of given low width, model predicts outcome
    task automatic strobe(input int low_cyc);
        bit inward, ok;
        @(negedge clk) step_n = 1'b0;
        repeat (low_cyc) @(negedge clk);
        inward = (dir_n == 1'b0);
        ok = (low_cyc >= 11) && sel && !wr_busy &&
             (inward ? (m_track < TMAX) : (m_track > 0));
        if (ok) begin
            m_track = inward ? m_track + 1 : m_track - 1;
            exp_q.push_back(m_track);
        end
        step_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic set_dir(input logic v);
        repeat (WIN + 10) @(negedge clk);
        dir_n = v;
        repeat (WIN + 10) @(negedge clk);
    endtask

    task automatic check_pos(input string req);
        chk(req, int'(track), m_track);
        chk(req, int'(phase), int'(gray_of(m_track)));
        chk(req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int pc, vc;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 phase", int'(phase), 0);
        chk("R1 track", int'(track), 0);
        chk("R1 trk0_n", int'(trk0_n), 0);
        chk("R1 pulse", int'(step_pulse), 0);
        chk("R1 viol", int'(dir_viol), 0);
        rst_n = 1'b1;
        set_dir(1'b0);

        // R2 width boundary
        pc = pulse_cnt;
        strobe(10);
        chk("R2 10-cycle rejected", pulse_cnt - pc, 0);
        check_pos("R2 pos after short");
        strobe(11);
        chk("R2 11-cycle accepted", pulse_cnt - pc, 1);
        check_pos("R2 pos after long");
        chk("R8 trk0_n off zero", int'(trk0_n), 1);

        // R3 no move while strobe held low
        @(negedge clk) step_n = 1'b0;
        repeat (40) @(negedge clk);
        chk("R3 track while low", int'(track), 1);
        step_n = 1'b1;
        m_track = 2;
        exp_q.push_back(2);
        repeat (8) @(negedge clk);
        check_pos("R3 after release");

        // R4 walk inward to the top, R7 top limit
        for (int i = 0; i < TMAX - 2; i++) strobe(12);
        check_pos("R4 at top");
        chk("R4 top track", int'(track), TMAX);
        pc = pulse_cnt;
        strobe(12);
        chk("R7 inward at top ignored", pulse_cnt - pc, 0);
        check_pos("R7 pos at top");

        // R5 walk outward, R7 bottom limit, R8
        set_dir(1'b1);
        for (int i = 0; i < TMAX; i++) strobe(15);
        check_pos("R5 at zero");
        chk("R8 trk0_n at zero", int'(trk0_n), 0);
        pc = pulse_cnt;
        strobe(12);
        chk("R7 outward at zero ignored", pulse_cnt - pc, 0);
        check_pos("R7 pos at zero");

        // R6 unselected / writing
        set_dir(1'b0);
        sel = 1'b0;
        pc = pulse_cnt;
        strobe(12);
        chk("R6 unselected ignored", pulse_cnt - pc, 0);
        check_pos("R6 pos unselected");
        sel = 1'b1;
        wr_busy = 1'b1;
        strobe(12);
        chk("R6 writing ignored", pulse_cnt - pc, 0);
        check_pos("R6 pos writing");
        wr_busy = 1'b0;
        chk("R9 total pulses", pulse_cnt, 2 * TMAX);

        // R12 steady direction
        vc = viol_cnt;
        strobe(12);
        repeat (WIN + 10) @(negedge clk);
        chk("R12 no violation", viol_cnt - vc, 0);
        check_pos("R12 pos");

        // R10 setup break: change then step soon
        vc = viol_cnt;
        @(negedge clk) dir_n = 1'b1;
        repeat (20) @(negedge clk);
        strobe(12);
        repeat (5) @(negedge clk);
        chk("R10 setup violation", viol_cnt - vc, 1);
        check_pos("R10 pos");

        // R11 hold break: change right after the step
        vc = viol_cnt;
        dir_n = 1'b0;
        repeat (WIN + 10) @(negedge clk);
        chk("R11 hold violation", viol_cnt - vc, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule